// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is a slave-only SMBus target that owns a small file of eight 8-bit control and status registers for a clock-distribution chip. Its 7-bit bus address is built from three strap inputs. The straps are sampled while reset is held, so later strap changes have no effect until the next reset. The block takes SCL and SDA inputs that are already synchronised to the local clock. It pulls SDA low through an open-drain enable output, and it never stretches the clock.

Two access styles are supported. With command 0x00 the access is a block transfer starting at register 0. On a write, the master sends a count and then that many data bytes. On a read, after a repeated start, the target first returns the count held in register 7 and then the data bytes. With a command of the form 100xxxxx the access is a single-byte transfer: the low five command bits select the register, and the master either writes one byte or reads one after a repeated start.

Registers 0 to 2 drive the output-control logic through `cfg_o`. Registers 3 and 4 report live output-enable pins and straps latched at reset. Register 5 is a revision code, register 6 is a device identifier, and register 7 holds the read-back count.

Top module: `smbcfg_target`

## Requirements
- R1: The target acknowledges only the address byte {4'b1101, strap_addr_i, R/W}, that is 0xD0 + 2*strap (D0, D2 ... DE). The straps are taken while rst_n is low and held afterwards. A non-matching address is not acknowledged, and the target ignores the bus until the next START.
- R2: After reset cfg_o[7:0] (register 0) is 0xF9 when strap_fs_i=1 and 0xE3 when strap_fs_i=0. Bits 7:5 are 1, bit 4 equals strap_fs_i, bit 3 equals strap_fs_i, bit 1 is its inverse, bit 0 is 1 and bit 2 is 0. cfg_o[15:8] (register 1) is 0xFF, cfg_o[23:16] (register 2) is 0xEF, and register 7 reads 0x07.
- R3: A byte write with command 100xxxxx stores the data byte into the register selected by bits 4:0, and the stored value appears on cfg_o for registers 0 to 2.
- R4: A byte read (command 100xxxxx, then a repeated start and the address with R/W=1) returns the selected register, MSB first.
- R5: A block write (command 0x00, count C, data bytes) writes the first C data bytes to registers 0, 1, 2 ... in order. Every byte is acknowledged, and data bytes beyond C change nothing.
- R6: A block read (command 0x00, repeated start, address with R/W=1) returns the value of register 7 first, then registers 0, 1, 2 ... while the host acknowledges.
- R7: Register 3 bit i reads oe_pin_n_i[i] for i=0..7. Register 4 bits 2:0 read oe_pin_n_i[10:8], bits 4:3 read 0, and bits 5, 6 and 7 read the reset-latched strap_addr_i[2], strap_bw_i and strap_fs_i.
- R8: Register 5 reads 0x00 and register 6 reads 0x0C. Writes to registers 3 to 6, writes to offsets above 7, and data after a command that is neither 0x00 nor 100xxxxx are acknowledged and ignored. Reads from offsets above 7 return 0x00.
- R9: A STOP in any state returns the target to idle with SDA released. A later transaction then works normally, even if the STOP cut a byte short.
- R10: sda_oe_o changes only in a cycle that follows a cycle with SCL low. It is high during the ninth clock of each byte the target accepts.
- R11: cfg_o changes only in a cycle that follows a cycle with SCL low, never during reset-free SCL-high phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| scl_i | input | 1 | Synchronised SCL |
| sda_i | input | 1 | Synchronised SDA (wired bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_addr_i | input | 3 | Address straps; bit 2 also reports the bypass strap |
| strap_fs_i | input | 1 | Frequency-select strap |
| strap_bw_i | input | 1 | Bandwidth-select strap |
| oe_pin_n_i | input | 11 | Live output-enable pins, 1 = disabled |
| cfg_o | output | 24 | Registers 2, 1, 0 as {reg2, reg1, reg0} |

## Verification
The hardest cases to reach are the ones where the target's view of a transfer differs from the host's. Examples are a STOP that cuts off a command byte after only three bits, and a block write whose host sends more bytes than the count it announced. The bench reaches them with a bit-level host model on a wired-AND SDA. Its STOP can be issued after any number of clocks, and its byte task sends any sequence, so a truncated command or a surplus data byte is sent on purpose. The bench then reads the registers back to show that nothing changed. The reset-sampled straps are covered by changing the straps after reset and checking which address is acknowledged.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_WRITE,
        PH_READ,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic                ack_slot;
        logic [3:0]          nbit;
        logic [BYTE_W-1:0]   shift;
        logic                drive;
        logic [PTR_W-1:0]    ptr;
        logic [BYTE_W-1:0]   left;
        logic                blk;
        logic                rnw;
        logic                rd_first;
        logic                host_ack;
        logic [2:0]          sa;
    } fsm_t;

    typedef struct packed {
        logic [BYTE_W-1:0] gear;
        logic [BYTE_W-1:0] en_lo;
        logic [BYTE_W-1:0] en_hi;
        logic [BYTE_W-1:0] bcnt;
        logic              fs;
        logic              bw;
        logic              byp;
    } bank_t;

endpackage

// File: rtl/smbcfg_line_mon.sv
module smbcfg_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '{scl: 1'b1, sda: 1'b1};
        else        line_q <= line_d;
    end

    // SDA transitions are conditions only while SCL stays high
    assign scl_rise_o = scl_i & ~line_q.scl;
    assign scl_fall_o = ~scl_i & line_q.scl;
    assign start_o    = scl_i & line_q.scl & line_q.sda & ~sda_i;
    assign stop_o     = scl_i & line_q.scl & ~line_q.sda & sda_i;

endmodule

// File: rtl/smbcfg_regbank.sv
module smbcfg_regbank
    import smbcfg_pkg::*;
#(
    parameter logic [7:0] DEV_ID   = 8'h0C,
    parameter logic [7:0] REV_ID   = 8'h00,
    parameter logic [7:0] BCNT_RST = 8'h07,
    parameter int         NOE      = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_fs_i,
    input  logic             strap_bw_i,
    input  logic             strap_byp_i,
    input  logic [NOE-1:0]   oe_pin_n_i,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o,
    output logic [23:0]      ctrl_o
);

    localparam int HI_PINS = NOE - 8;

    bank_t bank_d, bank_q, bank_rst;

    // Reset image: gear field code depends on the frequency-select strap
    always_comb begin
        bank_rst.gear  = {3'b111, strap_fs_i, strap_fs_i, 1'b0, ~strap_fs_i, 1'b1};
        bank_rst.en_lo = 8'hFF;
        bank_rst.en_hi = 8'hEF;
        bank_rst.bcnt  = BCNT_RST;
        bank_rst.fs    = strap_fs_i;
        bank_rst.bw    = strap_bw_i;
        bank_rst.byp   = strap_byp_i;
    end

    always_comb begin
        bank_d = bank_q;
        if (wr_en_i) begin
            case (wr_idx_i)
                7'd0:    bank_d.gear  = wr_data_i;
                7'd1:    bank_d.en_lo = wr_data_i;
                7'd2:    bank_d.en_hi = wr_data_i;
                7'd7:    bank_d.bcnt  = wr_data_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= bank_rst;
        else        bank_q <= bank_d;
    end

    logic [7:0] stat_hi;
    always_comb begin
        stat_hi = {bank_q.fs, bank_q.bw, bank_q.byp, 5'b0};
        stat_hi[HI_PINS-1:0] = oe_pin_n_i[NOE-1:8];
    end

    always_comb begin
        case (rd_idx_i)
            7'd0:    rd_data_o = bank_q.gear;
            7'd1:    rd_data_o = bank_q.en_lo;
            7'd2:    rd_data_o = bank_q.en_hi;
            7'd3:    rd_data_o = oe_pin_n_i[7:0];
            7'd4:    rd_data_o = stat_hi;
            7'd5:    rd_data_o = REV_ID;
            7'd6:    rd_data_o = DEV_ID;
            7'd7:    rd_data_o = bank_q.bcnt;
            default: rd_data_o = 8'h00;
        endcase
    end

    assign ctrl_o = {bank_q.en_hi, bank_q.en_lo, bank_q.gear};

endmodule

// File: rtl/smbcfg_proto.sv
module smbcfg_proto
    import smbcfg_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       strap_addr_i,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [7:0]       rd_data_i,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic             sda_oe_o
);

    localparam logic [PTR_W-1:0] PTR_MAX  = '1;
    localparam logic [PTR_W-1:0] CNT_IDX  = 7'd7;
    localparam logic [3:0]       LAST_BIT = 4'd8;

    fsm_t q, d, rst_val;
    logic use_cnt;
    logic [PTR_W-1:0] ptr_inc;
    logic [7:0] in_byte;

    always_comb begin
        rst_val          = '0;
        rst_val.ph       = PH_IDLE;
        rst_val.sa       = strap_addr_i;
    end

    assign use_cnt  = q.blk & q.rd_first;
    assign ptr_inc  = (q.ptr == PTR_MAX) ? q.ptr : q.ptr + 7'd1;
    assign in_byte  = q.shift;
    assign rd_idx_o = use_cnt ? CNT_IDX : q.ptr;

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        wr_idx_o  = q.ptr;
        wr_data_o = in_byte;

        if (stop_i) begin
            d.ph       = PH_IDLE;
            d.drive    = 1'b0;
            d.ack_slot = 1'b0;
        end else if (start_i) begin
            d.ph       = PH_ADDR;
            d.nbit     = '0;
            d.drive    = 1'b0;
            d.ack_slot = 1'b0;
        end else begin
            case (q.ph)
                PH_IDLE, PH_SKIP: ;

                PH_READ: begin
                    if (!q.ack_slot) begin
                        if (scl_rise_i) d.nbit = q.nbit + 4'd1;
                        if (scl_fall_i) begin
                            if (q.nbit == LAST_BIT) begin
                                d.drive    = 1'b0;
                                d.ack_slot = 1'b1;
                            end else begin
                                d.shift = {q.shift[6:0], 1'b0};
                                d.drive = ~q.shift[6];
                            end
                        end
                    end else begin
                        if (scl_rise_i) d.host_ack = ~sda_i;
                        if (scl_fall_i) begin
                            if (q.host_ack) begin
                                d.ack_slot = 1'b0;
                                d.nbit     = '0;
                                d.shift    = rd_data_i;
                                d.drive    = ~rd_data_i[7];
                                if (use_cnt) d.rd_first = 1'b0;
                                else         d.ptr      = ptr_inc;
                            end else begin
                                d.ph    = PH_SKIP;
                                d.drive = 1'b0;
                            end
                        end
                    end
                end

                default: begin
                    if (!q.ack_slot) begin
                        if (scl_rise_i) begin
                            d.shift = {q.shift[6:0], sda_i};
                            d.nbit  = q.nbit + 4'd1;
                        end
                        if (scl_fall_i && q.nbit == LAST_BIT) begin
                            d.drive    = 1'b1;
                            d.ack_slot = 1'b1;
                            case (q.ph)
                                PH_ADDR: begin
                                    if (in_byte[7:1] == {ADDR_HI, q.sa}) begin
                                        d.rnw      = in_byte[0];
                                        d.rd_first = in_byte[0];
                                    end else begin
                                        d.ph       = PH_SKIP;
                                        d.drive    = 1'b0;
                                        d.ack_slot = 1'b0;
                                    end
                                end
                                PH_CMD: begin
                                    if (in_byte == 8'h00) begin
                                        d.blk  = 1'b1;
                                        d.ptr  = '0;
                                        d.left = '0;
                                    end else begin
                                        d.blk  = 1'b0;
                                        d.left = 8'd1;
                                        d.ptr  = (in_byte[7:5] == 3'b100) ?
                                                 {2'b00, in_byte[4:0]} : PTR_MAX;
                                    end
                                end
                                PH_COUNT: d.left = in_byte;
                                PH_WRITE: begin
                                    if (q.left != '0) begin
                                        wr_en_o = 1'b1;
                                        d.left  = q.left - 8'd1;
                                        d.ptr   = ptr_inc;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end else if (scl_fall_i) begin
                        d.ack_slot = 1'b0;
                        d.nbit     = '0;
                        d.drive    = 1'b0;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.rnw) begin
                                    d.ph    = PH_READ;
                                    d.shift = rd_data_i;
                                    d.drive = ~rd_data_i[7];
                                    if (use_cnt) d.rd_first = 1'b0;
                                    else         d.ptr      = ptr_inc;
                                end else begin
                                    d.ph = PH_CMD;
                                end
                            end
                            PH_CMD:  d.ph = q.blk ? PH_COUNT : PH_WRITE;
                            default: d.ph = PH_WRITE;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_val;
        else        q <= d;
    end

    assign sda_oe_o = q.drive;

endmodule

// File: rtl/smbcfg_target.sv
module smbcfg_target
    import smbcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  strap_addr_i,
    input  logic        strap_fs_i,
    input  logic        strap_bw_i,
    input  logic [10:0] oe_pin_n_i,
    output logic [23:0] cfg_o
);

    logic scl_rise, scl_fall, cond_start, cond_stop;
    logic wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [7:0] wr_data, rd_data;

    smbcfg_line_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (cond_start),
        .stop_o     (cond_stop)
    );

    smbcfg_proto #(.ADDR_HI(4'b1101)) u_proto (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_addr_i (strap_addr_i),
        .sda_i        (sda_i),
        .scl_rise_i   (scl_rise),
        .scl_fall_i   (scl_fall),
        .start_i      (cond_start),
        .stop_i       (cond_stop),
        .rd_data_i    (rd_data),
        .rd_idx_o     (rd_idx),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_data_o    (wr_data),
        .sda_oe_o     (sda_oe_o)
    );

    smbcfg_regbank #(.NOE(11)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_fs_i  (strap_fs_i),
        .strap_bw_i  (strap_bw_i),
        .strap_byp_i (strap_addr_i[2]),
        .oe_pin_n_i  (oe_pin_n_i),
        .wr_en_i     (wr_en),
        .wr_idx_i    (wr_idx),
        .wr_data_i   (wr_data),
        .rd_idx_i    (rd_idx),
        .rd_data_o   (rd_data),
        .ctrl_o      (cfg_o)
    );

endmodule

// File: rtl/smbcfg_target_chk.sv
module smbcfg_target_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        sda_oe_o,
    input logic [23:0] cfg_o
);

    // R10
    oe_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_i));

    // R11
    cfg_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> !$past(scl_i));

    // R2
    rst_enlo_chk: assert property (@(posedge clk)
        !rst_n |=> cfg_o[15:8] == 8'hFF);

    // R2
    rst_enhi_chk: assert property (@(posedge clk)
        !rst_n |=> cfg_o[23:16] == 8'hEF);

    // R2
    rst_gear_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_o[7:5] == 3'b111) && (cfg_o[1] == ~cfg_o[3])
                   && (cfg_o[4] == cfg_o[3]) && cfg_o[0] && !cfg_o[2]);

endmodule

bind smbcfg_target smbcfg_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o)
);

// File: tb/test_smbcfg_target.sv
module test_smbcfg_target;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [2:0]  strap_addr = 3'b101;
    logic        strap_fs = 1'b1;
    logic        strap_bw = 1'b0;
    logic [10:0] oe_pins = 11'b101_0110_1001;
    logic [23:0] cfg;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smbcfg_target i_smbcfg_target (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (m_scl),
        .sda_i        (sda_bus),
        .sda_oe_o     (sda_oe),
        .strap_addr_i (strap_addr),
        .strap_fs_i   (strap_fs),
        .strap_bw_i   (strap_bw),
        .oe_pin_n_i   (oe_pins),
        .cfg_o        (cfg)
    );

    // {offset, write data, expected read}
    localparam logic [23:0] VEC [9] = '{
        {8'h00, 8'hA5, 8'hA5},   // R3 R4
        {8'h01, 8'h3C, 8'h3C},   // R3 R4
        {8'h02, 8'h5A, 8'h5A},   // R3 R4
        {8'h07, 8'h03, 8'h03},   // R3 R4
        {8'h03, 8'hFF, 8'h69},   // R7 R8
        {8'h04, 8'h00, 8'hA5},   // R7 R8
        {8'h05, 8'hFF, 8'h00},   // R8
        {8'h06, 8'hFF, 8'h0C},   // R8
        {8'h09, 8'h77, 8'h00}    // R8
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(2);
        m_scl = 1'b1; w(2);
        m_sda = 1'b0; w(2);
        m_scl = 1'b0; w(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(2);
        m_scl = 1'b1; w(2);
        m_sda = 1'b1; w(4);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            m_sda = b[i]; w(2);
            m_scl = 1'b1; w(4);
            m_scl = 1'b0; w(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; w(2);
        m_scl = 1'b1; w(2);
        ack = ~sda_bus; w(2);
        m_scl = 1'b0; w(2);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(2);
            m_scl = 1'b1; w(2);
            b[i] = sda_bus; w(2);
            m_scl = 1'b0; w(2);
        end
        m_sda = ~give_ack; w(2);
        m_scl = 1'b1; w(4);
        m_scl = 1'b0; w(2);
        m_sda = 1'b1;
    endtask

    task automatic byte_write(input logic [7:0] ab, input logic [7:0] off, input logic [7:0] dat);
        logic a;
        bus_start();
        send_byte(ab, a);
        send_byte(8'h80 | off, a);
        send_byte(dat, a);
        bus_stop();
    endtask

    task automatic byte_read(input logic [7:0] ab, input logic [7:0] off, output logic [7:0] dat);
        logic a;
        bus_start();
        send_byte(ab, a);
        send_byte(8'h80 | off, a);
        bus_start();
        send_byte(ab | 8'h01, a);
        recv_byte(1'b0, dat);
        bus_stop();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] rb;
        w(4);
        rst_n = 1'b1;
        w(2);

        // R2 reset image with fs strap high
        chk("R2 reset cfg", cfg, 24'hEF_FF_F9);
        byte_read(8'hDA, 8'h07, rb);
        chk("R2 count reg reset", rb, 8'h07);

        // R1 wrong address gets no acknowledge
        bus_start();
        send_byte(8'hD0, a);
        bus_stop();
        chk("R1 foreign address nack", a, 1'b0);
        bus_start();
        send_byte(8'hDA, a);
        bus_stop();
        chk("R1 own address ack", a, 1'b1);

        // R3 R4 R7 R8 table walk: write, then read back
        for (int i = 0; i < 9; i++) begin
            byte_write(8'hDA, VEC[i][23:16], VEC[i][15:8]);
            byte_read(8'hDA, VEC[i][23:16], rb);
            chk($sformatf("R3/R4/R7/R8 offset %0d", VEC[i][23:16]), rb, VEC[i][7:0]);
        end
        chk("R3 cfg after byte writes", cfg, 24'h5A_3C_A5);

        // R8 unsupported command: data acked and ignored
        bus_start();
        send_byte(8'hDA, a);
        send_byte(8'h40, a);
        send_byte(8'h12, a);
        bus_stop();
        chk("R8 odd command ack", a, 1'b1);
        chk("R8 odd command no effect", cfg, 24'h5A_3C_A5);

        // R5 block write, count 2, one surplus byte
        bus_start();
        send_byte(8'hDA, a);
        send_byte(8'h00, a);
        send_byte(8'h02, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        chk("R5 surplus byte acked", a, 1'b1);
        chk("R5 block write cfg", cfg, 24'h5A_22_11);

        // R6 block read: count (reg7 = 3) then regs 0,1,2
        bus_start();
        send_byte(8'hDA, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hDB, a);
        recv_byte(1'b1, rb); chk("R6 count byte", rb, 8'h03);
        recv_byte(1'b1, rb); chk("R6 data 0", rb, 8'h11);
        recv_byte(1'b1, rb); chk("R6 data 1", rb, 8'h22);
        recv_byte(1'b0, rb); chk("R6 data 2", rb, 8'h5A);
        bus_stop();

        // R9 STOP cuts a command byte short
        bus_start();
        send_byte(8'hDA, a);
        send_bits(8'h81, 3);
        bus_stop();
        chk("R9 bus released after stop", sda_oe, 1'b0);
        chk("R9 truncated write no effect", cfg, 24'h5A_22_11);
        byte_read(8'hDA, 8'h01, rb);
        chk("R9 normal access after stop", rb, 8'h22);

        // R7 live pins in register 3
        oe_pins = 11'b010_1100_0011;
        byte_read(8'hDA, 8'h03, rb);
        chk("R7 live oe pins", rb, 8'hC3);

        // R1 R2 R7 second reset with other straps
        rst_n = 1'b0;
        strap_addr = 3'b010;
        strap_fs = 1'b0;
        strap_bw = 1'b1;
        w(4);
        rst_n = 1'b1;
        w(2);
        strap_addr = 3'b101;
        chk("R2 reset cfg fs low", cfg, 24'hEF_FF_E3);
        bus_start();
        send_byte(8'hDA, a);
        bus_stop();
        chk("R1 straps sampled only in reset", a, 1'b0);
        byte_read(8'hD4, 8'h04, rb);
        chk("R7 latched straps and high pins", rb, 8'h42);
        byte_read(8'hD4, 8'h00, rb);
        chk("R4 gear reg read", rb, 8'hE3);

        finish_run();
    end

endmodule